// File: doc/BRIEF.md
# Twenty-Function 16-bit ALU

This block is a purely combinational arithmetic-logic unit for a small 16-bit datapath. It receives two operands, `x_in` and `y_in`, and a 5-bit function number. It returns a 16-bit result along with two status bits: one marks a zero result and one marks a negative result. The block holds no state. Any change on an input shows up at the outputs before the next clock edge of the surrounding logic.

The function number is a dense index into a fixed ordered table. The table holds the eighteen operations of a classic minimal computer ALU:

- constants
- pass-through and complement of either operand
- negation
- increment and decrement
- sum and both differences
- AND and OR

Two further operations follow them: bitwise XOR and XNOR. All arithmetic wraps modulo 2^16, and any carry out of the top bit is lost. Numbers past the end of the table give zero.

Top module: `alu20_core`

## Requirements
- R1: Codes 0, 1 and 2 give the constants 0x0000, 0x0001 and 0xFFFF, whatever the operands are.
- R2: Code 3 gives x, code 4 gives y, code 5 gives the bitwise complement of x and code 6 gives the bitwise complement of y.
- R3: Code 7 gives the two's-complement negation of x and code 8 gives the negation of y, both modulo 2^16.
- R4: Code 9 gives x+1, code 10 gives y+1, code 11 gives x-1 and code 12 gives y-1, all wrapping modulo 2^16.
- R5: Code 13 gives x+y, code 14 gives x-y and code 15 gives y-x, all modulo 2^16 with the carry discarded.
- R6: Code 16 gives the bitwise AND of x and y and code 17 gives their bitwise OR.
- R7: Code 18 gives the bitwise XOR of x and y and code 19 gives the bitwise XNOR.
- R8: Codes 20 to 31 give 0x0000 for every pair of operands.
- R9: `zero_flag` is 1 exactly when the 16-bit result is 0x0000.
- R10: `neg_flag` equals bit 15 of the result.
- R11: The outputs follow any change of operands or code without a clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 5 | Function number, 0 to 19 defined |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| result | output | 16 | Selected function value |
| zero_flag | output | 1 | Result is zero |
| neg_flag | output | 1 | Result bit 15 |

## Verification
Wraparound of the shared adder and the zero flag can happen in the same evaluation. For example, x+1 with x at 0xFFFF, or x-y with equal operands, produces a discarded carry together with a zero result. A second overlap comes from the sign boundary, where -x of 0x8000 keeps bit 15 set and so raises the negative flag at the same time.

The bench provokes both cases with directed operands 0xFFFF, 0x8000, 0x7FFF and equal pairs, run across every code. A behavioural integer model reduces its arithmetic modulo 65536 and derives both flags from its own expected value. The bench compares all three outputs on every clock.

// File: rtl/alu20_pkg.sv
package alu20_pkg;
  typedef enum logic [4:0] {
    FN_ZERO   = 5'd0,
    FN_ONE    = 5'd1,
    FN_ALL1   = 5'd2,
    FN_X      = 5'd3,
    FN_Y      = 5'd4,
    FN_NOTX   = 5'd5,
    FN_NOTY   = 5'd6,
    FN_NEGX   = 5'd7,
    FN_NEGY   = 5'd8,
    FN_XINC   = 5'd9,
    FN_YINC   = 5'd10,
    FN_XDEC   = 5'd11,
    FN_YDEC   = 5'd12,
    FN_ADD    = 5'd13,
    FN_XSUBY  = 5'd14,
    FN_YSUBX  = 5'd15,
    FN_AND    = 5'd16,
    FN_OR     = 5'd17,
    FN_XOR    = 5'd18,
    FN_XNOR   = 5'd19
  } alu_fn_e;

  localparam int unsigned FN_COUNT = 20;
endpackage

// File: rtl/alu20_arith.sv
module alu20_arith
  import alu20_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_fn_e      fn,
  output logic [W-1:0] sum,
  output logic         hit
);
  localparam logic [W-1:0] ZEROS = '0;
  localparam logic [W-1:0] ONES  = '1;

  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         carry_in;

  // one adder serves every arithmetic code; operands are conditioned per code
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic c);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    return full[W-1:0];
  endfunction

  always_comb begin
    op_a     = ZEROS;
    op_b     = ZEROS;
    carry_in = 1'b0;
    hit      = 1'b1;
    case (fn)
      FN_ZERO:  ;
      FN_ONE:   carry_in = 1'b1;
      FN_ALL1:  op_a = ONES;
      FN_X:     op_a = x;
      FN_Y:     op_b = y;
      FN_NEGX:  begin op_a = ~x; carry_in = 1'b1; end
      FN_NEGY:  begin op_b = ~y; carry_in = 1'b1; end
      FN_XINC:  begin op_a = x; carry_in = 1'b1; end
      FN_YINC:  begin op_b = y; carry_in = 1'b1; end
      FN_XDEC:  begin op_a = x; op_b = ONES; end
      FN_YDEC:  begin op_a = ONES; op_b = y; end
      FN_ADD:   begin op_a = x; op_b = y; end
      FN_XSUBY: begin op_a = x; op_b = ~y; carry_in = 1'b1; end
      FN_YSUBX: begin op_a = ~x; op_b = y; carry_in = 1'b1; end
      default:  hit = 1'b0;
    endcase
  end

  assign sum = wrap_add(op_a, op_b, carry_in);

  always_comb begin
    if (hit && fn == FN_XSUBY)
      assert_sub_inverse_R5: assert (wrap_add(sum, y, 1'b0) == x)
        else $error("x-y plus y does not give x");
    if (hit && fn == FN_NEGX)
      assert_negate_sum_R3: assert (wrap_add(sum, x, 1'b0) == ZEROS)
        else $error("-x plus x is not zero");
  end
endmodule

// File: rtl/alu20_bitwise.sv
module alu20_bitwise
  import alu20_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_fn_e      fn,
  output logic [W-1:0] bits,
  output logic         hit
);
  always_comb begin
    hit  = 1'b1;
    bits = '0;
    case (fn)
      FN_NOTX: bits = ~x;
      FN_NOTY: bits = ~y;
      FN_AND:  bits = x & y;
      FN_OR:   bits = x | y;
      FN_XOR:  bits = x ^ y;
      FN_XNOR: bits = ~(x ^ y);
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (hit && fn == FN_XNOR)
      assert_xnor_complement_R7: assert (&(bits ^ x ^ y))
        else $error("xnor result not complementary to x^y");
  end
endmodule

// File: rtl/alu20_flags.sv
module alu20_flags #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] value,
  output logic         is_zero,
  output logic         is_neg
);
  assign is_zero = ~|value;
  assign is_neg  = value[W-1];
endmodule

// File: rtl/alu20_core.sv
module alu20_core
  import alu20_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SEL_W = 5
) (
  input  logic [SEL_W-1:0] fn_sel,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             neg_flag
);
  localparam int unsigned LAST_FN = FN_COUNT - 1;

  alu_fn_e          fn;
  logic [WIDTH-1:0] arith_val;
  logic [WIDTH-1:0] bit_val;
  logic             arith_hit;
  logic             bit_hit;

  assign fn = alu_fn_e'(fn_sel);

  alu20_arith #(.W(WIDTH)) u_arith (
    .x(x_in), .y(y_in), .fn(fn), .sum(arith_val), .hit(arith_hit)
  );

  alu20_bitwise #(.W(WIDTH)) u_bits (
    .x(x_in), .y(y_in), .fn(fn), .bits(bit_val), .hit(bit_hit)
  );

  always_comb begin
    if (arith_hit)    result = arith_val;
    else if (bit_hit) result = bit_val;
    else              result = '0;
  end

  alu20_flags #(.W(WIDTH)) u_flags (
    .value(result), .is_zero(zero_flag), .is_neg(neg_flag)
  );

  always_comb begin
    assert_one_unit_R11: assert (!(arith_hit && bit_hit))
      else $error("two units claim the same code");
    if (32'(fn_sel) > LAST_FN)
      assert_unused_zero_R8: assert (result == '0 && zero_flag)
        else $error("unused code gave non-zero result");
    if (fn_sel == FN_ALL1)
      assert_all_ones_R1: assert (neg_flag && !zero_flag)
        else $error("all-ones constant flags wrong");
    assert_flags_exclusive_R10: assert (!(zero_flag && neg_flag))
      else $error("zero and negative both set");
  end
endmodule

// File: tb/sim_alu20_core.sv
`timescale 1ns/1ps
module sim_alu20_core;
  logic        clk = 1'b0;
  logic [4:0]  fn_sel = '0;
  logic [15:0] x_in = '0;
  logic [15:0] y_in = '0;
  logic [15:0] result;
  logic        zero_flag;
  logic        neg_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  alu20_core u0 (
    .fn_sel(fn_sel), .x_in(x_in), .y_in(y_in),
    .result(result), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  function automatic int model(int c, int xv, int yv);
    int r;
    case (c)
      0: r = 0;          1: r = 1;          2: r = 65535;
      3: r = xv;         4: r = yv;
      5: r = 65535 - xv; 6: r = 65535 - yv;
      7: r = 65536 - xv; 8: r = 65536 - yv;
      9: r = xv + 1;     10: r = yv + 1;
      11: r = xv + 65535; 12: r = yv + 65535;
      13: r = xv + yv;   14: r = xv + 65536 - yv; 15: r = yv + 65536 - xv;
      16: r = xv & yv;   17: r = xv | yv;
      18: r = xv ^ yv;   19: r = 65535 - (xv ^ yv);
      default: r = 0;
    endcase
    return r % 65536;
  endfunction

  function automatic string req_of(int c);
    if (c <= 2)  return "R1";
    if (c <= 6)  return "R2";
    if (c <= 8)  return "R3";
    if (c <= 12) return "R4";
    if (c <= 15) return "R5";
    if (c <= 17) return "R6";
    if (c <= 19) return "R7";
    return "R8";
  endfunction

  task automatic compare(int c, int xv, int yv);
    int exp_v = model(c, xv, yv);
    bit exp_z = (exp_v == 0);
    bit exp_n = (exp_v >= 32768);
    checks++;
    if (int'(result) != exp_v) begin
      failures++;
      $display("FAIL %s code=%0d x=%h y=%h result=%h expected=%h",
               req_of(c), c, xv[15:0], yv[15:0], result, exp_v[15:0]);
    end
    checks++;
    if (zero_flag != exp_z) begin
      failures++;
      $display("FAIL R9 code=%0d zero_flag=%0b expected=%0b", c, zero_flag, exp_z);
    end
    checks++;
    if (neg_flag != exp_n) begin
      failures++;
      $display("FAIL R10 code=%0d neg_flag=%0b expected=%0b", c, neg_flag, exp_n);
    end
  endtask

  task automatic apply(int c, int xv, int yv);
    @(posedge clk);
    #1;
    fn_sel = 5'(c);
    x_in   = 16'(xv);
    y_in   = 16'(yv);
    @(negedge clk);
    compare(c, xv, yv);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pairs_x[8] = '{0, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234, 5, 16'hAAAA, 16'hFFFF};
    int pairs_y[8] = '{0, 1, 16'h8000, 1, 16'h1234, 9, 16'h5555, 16'hFFFF};
    // idle inputs: code 0 with zero operands (R1, R9)
    #2;
    compare(0, 0, 0);
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 8; p++) apply(c, pairs_x[p], pairs_y[p]);
      for (int k = 0; k < 20; k++)
        apply(c, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
    end
    // R11: change operands between edges and observe within 1 ns
    @(negedge clk);
    fn_sel = 5'd13; x_in = 16'h0003; y_in = 16'h0004;
    #1;
    checks++;
    if (result != 16'h0007) begin
      failures++;
      $display("FAIL R11 result=%h expected=0007", result);
    end
    x_in = 16'hFFFF; y_in = 16'h0001;
    #1;
    checks++;
    if (result != 16'h0000 || !zero_flag) begin
      failures++;
      $display("FAIL R11 result=%h zf=%0b expected=0000 zf=1", result, zero_flag);
    end
    finish_run();
  end
endmodule